// File: doc/BRIEF.md
# Multiply Bus Cycle Sequencer

This block drives the external bus control outputs of a processor for the full length of a multiply-family instruction. A one-cycle start strobe carries the instruction variant, the program counter, the multiplier operand and the state of the compact (half-width) instruction mode. From that point on, the block runs one prefetch cycle, then a run of internal cycles, and ends with a cycle that announces a sequential memory access. The length of the run depends on the multiplier value through early termination, and each variant adds its own fixed number of internal cycles.

The block only counts cycles and drives the address, size and strobe outputs. The multiplier datapath is outside it. The block reads the multiplier operand only to find how many 8-bit slices must be processed before the remaining upper bits are all zeros or all ones. While idle, the bus outputs sit at a fixed quiet pattern.

Top module: `mul_bus_seq`

## Requirements
- R1: While idle, and after reset, the outputs are addr_o=0, write_o=0, size_o=0, mreq_n_o=1, seq_o=0, opc_n_o=1 and done_o=0.
- R2: The first cycle of an accepted operation is the cycle after the start edge. It is a prefetch cycle, with opc_n_o=0, seq_o=0, mreq_n_o=1 and addr_o = pc+2L, where L is 4 in normal mode and 2 in compact mode.
- R3: In every cycle after the first, opc_n_o=1. write_o stays at 0 (read) for the whole operation.
- R4: Every cycle between the first and the last gives mreq_n_o=1 and seq_o=0. The last cycle gives mreq_n_o=0 and seq_o=1.
- R5: The termination count m is the smallest j in 1..3 for which multiplier_i[31:8j] is all zeros or all ones. If no such j exists, m is 4.
- R6: variant_i encodes 0 plain, 1 accumulate, 2 long and 3 accumulate-long. An operation lasts m+1, m+2, m+2 or m+3 cycles for these variants, in that order.
- R7: For the plain and long variants, addr_o is pc+2L in cycle 1 and pc+3L from cycle 2 on. For the accumulate variants, addr_o is pc+2L in cycles 1 and 2 and pc+3L from cycle 3 on.
- R8: size_o is 2'b10 (word) in every cycle of an accumulate variant. For the plain and long variants, size_o is 2'b10 in normal mode and 2'b01 (halfword) in compact mode.
- R9: A start with compact_i=1 and variant_i other than 0 is rejected. The outputs stay at the idle pattern.
- R10: done_o is high for exactly one cycle, the last cycle of the operation.
- R11: A start strobe that arrives while an operation runs, including during its last cycle, is ignored. The running operation keeps its length and addresses.
- R12: A plain multiply is accepted in compact mode and uses L=2 offsets with the halfword size code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| variant_i | input | 2 | Multiply variant: 0 plain, 1 acc, 2 long, 3 acc-long |
| compact_i | input | 1 | Compact instruction mode active |
| pc_i | input | 32 | Program counter at start |
| multiplier_i | input | 32 | Multiplier operand used for early termination |
| addr_o | output | 32 | Bus address |
| write_o | output | 1 | Write strobe, 0 = read |
| size_o | output | 2 | Transfer size code |
| mreq_n_o | output | 1 | Memory request inactive |
| seq_o | output | 1 | Sequential access flag |
| opc_n_o | output | 1 | Opcode fetch inactive |
| done_o | output | 1 | Last cycle of the operation |

## Verification
The test runs all four variants with multiplier values that end at each slice boundary, using both positive values and sign-extended negative values, including 0x80000000. A cycle count that is wrong for a single m value or a single variant therefore shows up directly. Runs in normal and compact mode separate the L=4 offsets and word size from the L=2 offsets and halfword size. The test applies illegal compact starts and starts issued in the middle of an operation and during its last cycle. These show whether a rejected or ignored strobe changes the bus, the addresses or the cycle count. Back-to-back operations check the handover from the last cycle to the next prefetch.

// File: rtl/mul_seq_pkg.sv
package mul_seq_pkg;
  typedef enum logic [1:0] {
    MV_PLAIN   = 2'd0,
    MV_ACC     = 2'd1,
    MV_LONG    = 2'd2,
    MV_ACCLONG = 2'd3
  } mul_var_e;

  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  function automatic logic var_has_acc(mul_var_e v);
    return v[0];
  endfunction

  function automatic logic var_has_long(mul_var_e v);
    return v[1];
  endfunction
endpackage

// File: rtl/mul_term_count.sv
module mul_term_count #(
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 8,
  localparam int NSLICE = DATA_W / SLICE_W,
  localparam int CNT_W  = $clog2(NSLICE + 1)
) (
  input  logic [DATA_W-1:0] operand_i,
  output logic [CNT_W-1:0]  m_o
);
  logic [NSLICE-1:0] uniform;

  assign uniform[0] = 1'b0;
  // upper bits above slice j all sign-equal
  for (genvar j = 1; j < NSLICE; j++) begin : g_slice
    assign uniform[j] = (&operand_i[DATA_W-1:j*SLICE_W]) | ~(|operand_i[DATA_W-1:j*SLICE_W]);
  end

  always_comb begin
    m_o = CNT_W'(NSLICE);
    for (int j = NSLICE - 1; j >= 1; j--) begin
      if (uniform[j]) m_o = CNT_W'(j);
    end
  end
endmodule

// File: rtl/mul_cycle_ctr.sv
module mul_cycle_ctr #(
  parameter int TOT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TOT_W-1:0] total_i,
  output logic             busy_o,
  output logic [TOT_W-1:0] cyc_o,
  output logic             last_o
);
  logic [TOT_W-1:0] total_q;

  assign last_o = busy_o && (cyc_o == total_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      cyc_o   <= '0;
      total_q <= '0;
    end else if (busy_o) begin
      if (last_o) begin
        busy_o <= 1'b0;
        cyc_o  <= '0;
      end else begin
        cyc_o <= cyc_o + 1'b1;
      end
    end else if (load_i) begin
      busy_o  <= 1'b1;
      cyc_o   <= TOT_W'(1);
      total_q <= total_i;
    end
  end

  // R6
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !last_o |=> busy_o && (cyc_o == $past(cyc_o) + 1'b1));
  // R6
  end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !busy_o);
endmodule

// File: rtl/mul_bus_drive.sv
module mul_bus_drive
  import mul_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TOT_W  = 3
) (
  input  logic              busy_i,
  input  logic [TOT_W-1:0]  cyc_i,
  input  logic              last_i,
  input  mul_var_e          var_i,
  input  logic              compact_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              write_o,
  output logic [1:0]        size_o,
  output logic              mreq_n_o,
  output logic              seq_o,
  output logic              opc_n_o
);
  logic [ADDR_W-1:0] step, near_addr, far_addr;
  logic              hold_near;

  assign step      = compact_i ? ADDR_W'(2) : ADDR_W'(4);
  assign near_addr = pc_i + (step << 1);
  assign far_addr  = pc_i + (step << 1) + step;
  // accumulate forms keep pc+2L one extra cycle
  assign hold_near = (cyc_i == TOT_W'(1)) || (var_has_acc(var_i) && cyc_i == TOT_W'(2));

  always_comb begin
    addr_o   = '0;
    write_o  = 1'b0;
    size_o   = 2'b00;
    mreq_n_o = 1'b1;
    seq_o    = 1'b0;
    opc_n_o  = 1'b1;
    if (busy_i) begin
      addr_o   = hold_near ? near_addr : far_addr;
      size_o   = (var_has_acc(var_i) || !compact_i) ? SZ_WORD : SZ_HALF;
      opc_n_o  = (cyc_i != TOT_W'(1));
      mreq_n_o = !last_i;
      seq_o    = last_i;
    end
  end
endmodule

// File: rtl/mul_bus_seq.sv
module mul_bus_seq
  import mul_seq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 8,
  localparam int NSLICE = DATA_W / SLICE_W,
  localparam int CNT_W  = $clog2(NSLICE + 1),
  localparam int TOT_W  = $clog2(NSLICE + 4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        variant_i,
  input  logic              compact_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] multiplier_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              write_o,
  output logic [1:0]        size_o,
  output logic              mreq_n_o,
  output logic              seq_o,
  output logic              opc_n_o,
  output logic              done_o
);
  mul_var_e          var_in, var_q;
  logic              compact_q, illegal, load, busy, last;
  logic [ADDR_W-1:0] pc_q;
  logic [CNT_W-1:0]  m_w;
  logic [TOT_W-1:0]  total_w, cyc;

  assign var_in  = mul_var_e'(variant_i);
  assign illegal = compact_i && (var_in != MV_PLAIN);
  assign load    = start_i && !busy && !illegal;
  assign total_w = TOT_W'(m_w) + TOT_W'(1) + TOT_W'(var_has_acc(var_in)) + TOT_W'(var_has_long(var_in));

  mul_term_count #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_term (
    .operand_i (multiplier_i),
    .m_o       (m_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      var_q     <= MV_PLAIN;
      compact_q <= 1'b0;
      pc_q      <= '0;
    end else if (load) begin
      var_q     <= var_in;
      compact_q <= compact_i;
      pc_q      <= pc_i;
    end
  end

  mul_cycle_ctr #(.TOT_W(TOT_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .total_i (total_w),
    .busy_o  (busy),
    .cyc_o   (cyc),
    .last_o  (last)
  );

  mul_bus_drive #(.ADDR_W(ADDR_W), .TOT_W(TOT_W)) u_drive (
    .busy_i    (busy),
    .cyc_i     (cyc),
    .last_i    (last),
    .var_i     (var_q),
    .compact_i (compact_q),
    .pc_i      (pc_q),
    .addr_o    (addr_o),
    .write_o   (write_o),
    .size_o    (size_o),
    .mreq_n_o  (mreq_n_o),
    .seq_o     (seq_o),
    .opc_n_o   (opc_n_o)
  );

  assign done_o = last;

  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4
  final_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> seq_o && !mreq_n_o && opc_n_o);
  // R2
  prefetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !opc_n_o && !seq_o && mreq_n_o);
  // R3
  internal_opc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && $past(busy) && !$past(done_o) |-> opc_n_o && !write_o);
  // R9
  reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && illegal && !busy |=> !busy);
  // R11
  hold_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !done_o |=> $stable(pc_q) && $stable(var_q) && $stable(compact_q));
  // R5
  m_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> (m_w >= CNT_W'(1)) && (m_w <= CNT_W'(NSLICE)));
endmodule

// File: tb/mul_bus_seq_bench.sv
module mul_bus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  variant = 2'd0;
  logic        compact = 1'b0;
  logic [31:0] pc = '0;
  logic [31:0] mplier = '0;
  logic [31:0] addr;
  logic        wr, mreq_n, seq, opc_n, done;
  logic [1:0]  size;

  int checks = 0;
  int errors = 0;

  // model state
  int mb = 0, mc = 0, mt = 0, mvar = 0, mcomp = 0;
  logic [31:0] mpc = '0;

  always #4 clk = ~clk;

  mul_bus_seq u_mul_bus_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .variant_i(variant),
    .compact_i(compact), .pc_i(pc), .multiplier_i(mplier),
    .addr_o(addr), .write_o(wr), .size_o(size), .mreq_n_o(mreq_n),
    .seq_o(seq), .opc_n_o(opc_n), .done_o(done)
  );

  function automatic int ref_m(logic [31:0] v);
    for (int j = 1; j < 4; j++) begin
      logic [31:0] hi = v >> (8 * j);
      logic [31:0] ones = 32'hFFFF_FFFF >> (8 * j);
      if (hi == 0 || hi == ones) return j;
    end
    return 4;
  endfunction

  function automatic int ref_len(int vr, logic [31:0] v);
    int extra [4] = '{1, 2, 2, 3};
    return ref_m(v) + extra[vr];
  endfunction

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb = 0; mc = 0; mt = 0;
    end else if (mb != 0) begin
      if (mc == mt) begin mb = 0; mc = 0; end
      else mc++;
    end else if (start && !(compact && variant != 0)) begin
      mb = 1; mc = 1; mt = ref_len(variant, mplier);
      mvar = variant; mcomp = compact; mpc = pc;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] e_addr;
      logic [1:0]  e_size;
      int          l, near_n;
      logic        e_mreq_n, e_seq, e_opc_n, e_done;
      e_addr = 0; e_size = 0; e_mreq_n = 1; e_seq = 0; e_opc_n = 1; e_done = 0;
      if (mb != 0) begin
        l = mcomp ? 2 : 4;
        near_n = (mvar == 1 || mvar == 3) ? 2 : 1;
        e_addr = (mc <= near_n) ? mpc + 2 * l : mpc + 3 * l;
        e_size = (mvar == 1 || mvar == 3 || !mcomp) ? 2'b10 : 2'b01;
        e_opc_n = (mc != 1);
        e_mreq_n = (mc != mt);
        e_seq = (mc == mt);
        e_done = (mc == mt);
      end
      chk(addr == e_addr, "R7 addr", addr, e_addr);
      chk(size == e_size, "R8 size", size, e_size);
      chk(opc_n == e_opc_n, "R2/R3 opc_n", opc_n, e_opc_n);
      chk(wr == 1'b0, "R3 write", wr, 0);
      chk(mreq_n == e_mreq_n && seq == e_seq, "R4 mreq_n/seq", {mreq_n, seq}, {e_mreq_n, e_seq});
      chk(done == e_done, "R10 done", done, e_done);
    end
  end

  task automatic pulse(input int vr, input bit cm, input logic [31:0] p, input logic [31:0] op);
    @(negedge clk);
    start = 1'b1; variant = 2'(vr); compact = cm; pc = p; mplier = op;
    @(negedge clk);
    start = 1'b0;
  endtask

  // run one op, return observed cycle index of done (0 if never)
  task automatic run_op(input int vr, input bit cm, input logic [31:0] p,
                        input logic [31:0] op, output int n);
    pulse(vr, cm, p, op);
    n = 1;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
    if (!done) n = 0;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int exp_tab [4] = '{1, 2, 2, 3};
    logic [31:0] ops [7] = '{32'h0000_0005, 32'hFFFF_FF80, 32'h0000_1234,
                             32'hFFFF_8000, 32'h0012_3456, 32'h1234_5678, 32'h8000_0000};
    int ms [7] = '{1, 1, 2, 2, 3, 4, 4};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(addr == 0 && size == 0 && mreq_n && !seq && opc_n && !done && !wr, "R1 reset outputs",
        {addr, size, mreq_n, seq, opc_n, done}, {32'h0, 2'b00, 4'b1010});
    rst_n = 1'b1;
    @(negedge clk);
    chk(mreq_n && opc_n && !done, "R1 idle after reset", {mreq_n, opc_n, done}, 3'b110);

    // R5 R6 all variants, all m values
    for (int v = 0; v < 4; v++) begin
      for (int i = 0; i < 7; i++) begin
        run_op(v, 1'b0, 32'h0000_1000 + 32'(i * 64), ops[i], n);
        chk(n == ms[i] + exp_tab[v], $sformatf("R5/R6 length var%0d op%0h", v, ops[i]), n, ms[i] + exp_tab[v]);
      end
    end

    // R12 compact plain
    run_op(0, 1'b1, 32'h0000_2000, 32'h0000_1234, n);
    chk(n == 3, "R12 compact plain length", n, 3);

    // R9 illegal variants in compact mode
    for (int v = 1; v < 4; v++) begin
      pulse(v, 1'b1, 32'h0000_3000, 32'h0000_0001);
      n = 0;
      for (int k = 0; k < 6; k++) begin
        if (!opc_n || done || !mreq_n) n++;
        @(negedge clk);
      end
      chk(n == 0, $sformatf("R9 reject var%0d", v), n, 0);
    end

    // R11 start during run and during last cycle
    pulse(3, 1'b0, 32'h0000_4000, 32'h1234_5678);
    @(negedge clk);
    start = 1'b1; variant = 2'd0; pc = 32'h0000_5000; mplier = 32'h1;
    @(negedge clk);
    start = 1'b0;
    n = 3;
    while (!done && n < 20) begin @(negedge clk); n++; end
    chk(n == 7, "R11 length unchanged by busy start", n, 7);
    start = 1'b1; variant = 2'd1; pc = 32'h0000_6000; mplier = 32'h1;
    @(negedge clk);
    start = 1'b0;
    chk(opc_n && !done, "R11 start in last cycle ignored", {opc_n, done}, 2'b10);
    repeat (2) @(negedge clk);

    // back-to-back handover
    run_op(1, 1'b0, 32'h0000_7000, 32'hFFFF_FFFF, n);
    chk(n == 3, "R6 back-to-back first", n, 3);
    run_op(2, 1'b0, 32'h0000_7100, 32'h0000_00FF, n);
    chk(n == 3, "R6 back-to-back second", n, 3);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule